// File: doc/BRIEF.md
# Two-slot-per-period TDM to TDM8 reframer

This block takes a serial audio stream in which each word-clock period holds only two channel slots. A full set of eight channels is therefore spread over four word-clock periods in a row, and the stream is rewritten as a standard TDM8 stream that carries one frame sync per eight slots. The word clock repeats four times per frame, so it cannot mark where a frame starts. An external alignment enable supplies that reference. The source raises it once the first channel slot of a frame has gone by.

All logic runs on the bit clock. Inputs are sampled on its rising edge and outputs change on its falling edge. The block first deserializes each word-clock period into one word. It holds three of these words and, when the fourth arrives, hands the whole eight-channel frame to an output shifter. The shifter sends the frame out MSB first in channel order 1 to 8 while the next frame is collected. A polarity input selects which word-clock edge starts a period. The block checks the length of every period while it is locked, and any deviation drops lock until a fresh enable arrives.

Top module: `tdm_reframer`

## Requirements
- R1: `pol_rise` high makes a rising `lrclk` edge start a period, and low makes a falling edge start it. Bits are counted from that edge, and the first data bit is sampled one bit clock after it.
- R2: A period holds two slots of SLOT_W bits each, MSB first. The four periods that follow the anchor carry channels 1-2, 3-4, 5-6 and 7-8 in that order, and the pattern then repeats.
- R3: Without an alignment enable, `locked` stays low no matter how many word-clock edges arrive.
- R4: The first active word-clock edge after `align_en` goes high (having been seen low) closes the channel 1-2 period. `locked` rises at that edge and is visible in the following cycle.
- R5: While `locked` is low, `fs_out` and `sd_out` are both 0.
- R6: `fs_out` is a pulse one bit clock wide, repeated every 8*SLOT_W bit clocks while locked. It coincides with the MSB of channel 1 and starts on the falling edge after the frame's last input bit is sampled.
- R7: The 8*SLOT_W bits sent after each `fs_out` pulse equal the frame's input bits in the order they arrived (channel 1 MSB first through channel 8 LSB).
- R8: While locked, a period shorter than 2*SLOT_W bit clocks, or one that runs past 2*SLOT_W bit clocks without an active edge, sets `err` and clears `locked`.
- R9: After an error the block does not relock while `align_en` stays high. It relocks only after `align_en` has been seen low and then high again, and `err` clears at that new anchor.
- R10: After reset, `locked`, `err`, `fs_out` and `sd_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bclk | input | 1 | Bit clock; inputs sampled on rising edge, outputs driven on falling edge |
| rst | input | 1 | Synchronous active-high reset |
| lrclk | input | 1 | Word clock of the input stream, one period per two slots |
| sdin | input | 1 | Serial input data, MSB first |
| align_en | input | 1 | Alignment enable, raised during the channel 1-2 period |
| pol_rise | input | 1 | 1: rising word-clock edge starts a period; 0: falling edge |
| fs_out | output | 1 | TDM8 frame sync pulse |
| sd_out | output | 1 | TDM8 serial data |
| locked | output | 1 | Frame alignment established |
| err | output | 1 | Period length violation seen since the last anchor |

## Verification
The assertions assume that `pol_rise` changes only under reset. They also assume that `align_en` rises only while the channel 1-2 period is in flight, after its first slot. Without that, a lock on a wrong period would still satisfy every property. The bench changes polarity only with reset held and raises the enable at the first bit of the channel-2 slot. It breaks the period length only on purpose: once with a short period and once with a long one, each while locked.

// File: rtl/tdm_reframe_pkg.sv
package tdm_reframe_pkg;

    localparam int SLOTS_PER_PERIOD  = 2;
    localparam int PERIODS_PER_FRAME = 4;
    localparam int DEF_SLOT_W        = 32;

    typedef enum logic {
        ST_SEEK = 1'b0,
        ST_LOCK = 1'b1
    } align_state_e;

    // Event produced once per bit clock by the period tracker
    typedef struct packed {
        logic start;    // active word-clock edge sampled this cycle
        logic len_bad;  // period length differs from the nominal one
    } period_evt_t;

    function automatic int period_bits(input int slot_w);
        return slot_w * SLOTS_PER_PERIOD;
    endfunction

    function automatic int frame_bits(input int slot_w);
        return slot_w * SLOTS_PER_PERIOD * PERIODS_PER_FRAME;
    endfunction

endpackage

// File: rtl/rf_edge_track.sv
module rf_edge_track
    import tdm_reframe_pkg::*;
#(
    parameter int PERIOD_BITS = 64
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        lrclk,
    input  logic        pol_rise,
    output period_evt_t evt
);
    localparam int             CW   = $clog2(PERIOD_BITS + 1);
    localparam logic [CW-1:0]  LAST = CW'(PERIOD_BITS - 1);

    logic          lr_q;
    logic [CW-1:0] cnt;
    logic          start;

    assign start = (lrclk != lr_q) && (lrclk == pol_rise);

    always_ff @(posedge clk) begin
        if (rst) begin
            lr_q <= pol_rise;
            cnt  <= LAST;
        end else begin
            lr_q <= lrclk;
            if (start)
                cnt <= '0;
            else if (cnt != LAST)
                cnt <= cnt + 1'b1;
        end
    end

    // An edge must come exactly when the count reaches LAST; reaching LAST
    // with no edge means the period is too long.
    always_comb begin
        evt.start   = start;
        evt.len_bad = start ? (cnt != LAST) : (cnt == LAST);
    end

endmodule

// File: rtl/rf_period_shift.sv
module rf_period_shift #(
    parameter int PERIOD_BITS = 64
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   sdin,
    input  logic                   clear,
    output logic [PERIOD_BITS-1:0] word
);
    logic [PERIOD_BITS-2:0] sh;

    // The word includes the bit sampled in the current cycle, so it is
    // complete on the same edge that closes the period.
    assign word = {sh, sdin};

    always_ff @(posedge clk) begin
        if (rst || clear)
            sh <= '0;
        else
            sh <= word[PERIOD_BITS-2:0];
    end

endmodule

// File: rtl/rf_frame_build.sv
module rf_frame_build
    import tdm_reframe_pkg::*;
#(
    parameter int SLOT_W = DEF_SLOT_W
) (
    input  logic                        clk,
    input  logic                        rst,
    input  period_evt_t                 evt,
    input  logic [period_bits(SLOT_W)-1:0] word,
    input  logic                        align_en,
    output logic                        locked,
    output logic                        err,
    output logic                        frame_close,
    output logic                        frame_valid,
    output logic [frame_bits(SLOT_W)-1:0]  frame_q
);
    localparam int             PB    = period_bits(SLOT_W);
    localparam int             FB    = frame_bits(SLOT_W);
    localparam int             NP    = PERIODS_PER_FRAME;
    localparam int             PW    = $clog2(NP);
    localparam logic [PW-1:0]  LASTP = PW'(NP - 1);

    align_state_e  st;
    logic          armed;
    logic [PW-1:0] pidx;
    logic [PB-1:0] held [NP];
    logic [FB-1:0] full;

    // Frame image: held periods in the upper part, closing word at the bottom
    for (genvar gi = 0; gi < NP - 1; gi++) begin : g_pack
        assign full[FB-1-gi*PB -: PB] = held[gi];
    end
    assign full[PB-1:0] = word;

    assign locked      = (st == ST_LOCK);
    assign frame_close = locked && evt.start && !evt.len_bad && (pidx == LASTP);

    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= ST_SEEK;
            armed       <= 1'b0;
            err         <= 1'b0;
            pidx        <= '0;
            frame_valid <= 1'b0;
            frame_q     <= '0;
            for (int i = 0; i < NP; i++) held[i] <= '0;
        end else begin
            frame_valid <= 1'b0;
            unique case (st)
                ST_SEEK: begin
                    if (!align_en) begin
                        armed <= 1'b1;
                    end else if (evt.start && armed) begin
                        st      <= ST_LOCK;
                        armed   <= 1'b0;
                        err     <= 1'b0;
                        held[0] <= word;
                        pidx    <= PW'(1);
                    end
                end
                ST_LOCK: begin
                    if (evt.len_bad) begin
                        st   <= ST_SEEK;
                        err  <= 1'b1;
                        pidx <= '0;
                        for (int i = 0; i < NP; i++) held[i] <= '0;
                    end else if (frame_close) begin
                        frame_q     <= full;
                        frame_valid <= 1'b1;
                        pidx        <= '0;
                        for (int i = 0; i < NP; i++) held[i] <= '0;
                    end else if (evt.start) begin
                        held[pidx] <= word;
                        pidx       <= pidx + 1'b1;
                    end
                end
                default: st <= ST_SEEK;
            endcase
        end
    end

endmodule

// File: rtl/rf_tdm8_ser.sv
module rf_tdm8_ser #(
    parameter int FRAME_BITS = 256
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  run,
    input  logic                  load,
    input  logic [FRAME_BITS-1:0] frame,
    output logic                  fs_out,
    output logic                  sd_out
);
    logic [FRAME_BITS-1:0] osh;

    // Falling-edge launch so the receiver samples on the rising edge
    always_ff @(negedge clk) begin
        if (rst || !run) begin
            osh    <= '0;
            fs_out <= 1'b0;
            sd_out <= 1'b0;
        end else if (load) begin
            sd_out <= frame[FRAME_BITS-1];
            osh    <= {frame[FRAME_BITS-2:0], 1'b0};
            fs_out <= 1'b1;
        end else begin
            sd_out <= osh[FRAME_BITS-1];
            osh    <= {osh[FRAME_BITS-2:0], 1'b0};
            fs_out <= 1'b0;
        end
    end

endmodule

// File: rtl/tdm_reframer.sv
module tdm_reframer
    import tdm_reframe_pkg::*;
#(
    parameter int SLOT_W = DEF_SLOT_W
) (
    input  logic bclk,
    input  logic rst,
    input  logic lrclk,
    input  logic sdin,
    input  logic align_en,
    input  logic pol_rise,
    output logic fs_out,
    output logic sd_out,
    output logic locked,
    output logic err
);
    localparam int PB = period_bits(SLOT_W);
    localparam int FB = frame_bits(SLOT_W);

    period_evt_t   evt;
    logic [PB-1:0] word;
    logic          frame_close;
    logic          frame_valid;
    logic [FB-1:0] frame_q;

    rf_edge_track #(.PERIOD_BITS(PB)) edge_i (
        .clk      (bclk),
        .rst      (rst),
        .lrclk    (lrclk),
        .pol_rise (pol_rise),
        .evt      (evt)
    );

    rf_period_shift #(.PERIOD_BITS(PB)) shift_i (
        .clk   (bclk),
        .rst   (rst),
        .sdin  (sdin),
        .clear (frame_close),
        .word  (word)
    );

    rf_frame_build #(.SLOT_W(SLOT_W)) build_i (
        .clk         (bclk),
        .rst         (rst),
        .evt         (evt),
        .word        (word),
        .align_en    (align_en),
        .locked      (locked),
        .err         (err),
        .frame_close (frame_close),
        .frame_valid (frame_valid),
        .frame_q     (frame_q)
    );

    rf_tdm8_ser #(.FRAME_BITS(FB)) ser_i (
        .clk    (bclk),
        .rst    (rst),
        .run    (locked),
        .load   (frame_valid),
        .frame  (frame_q),
        .fs_out (fs_out),
        .sd_out (sd_out)
    );

endmodule

// File: rtl/tdm_reframer_chk.sv
module tdm_reframer_chk (
    input logic clk,
    input logic rst,
    input logic align_en,
    input logic locked,
    input logic err,
    input logic fs_out,
    input logic sd_out
);
    // R4: lock is only ever gained with the enable high at the anchor edge
    a_r4_lock_after_enable: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> $past(align_en));

    // R9: a fresh anchor leaves the error flag cleared
    a_r9_lock_clears_err: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> !err);

    // R8: an error only appears when dropping out of lock
    a_r8_err_drops_lock: assert property (@(posedge clk) disable iff (rst)
        $rose(err) |-> (!locked && $past(locked)));

    // R5: output stream is silent while unlocked
    a_r5_quiet_unlocked: assert property (@(posedge clk) disable iff (rst)
        !locked |-> (!fs_out && !sd_out));

    // R6: frame sync is never wider than one bit clock
    a_r6_sync_single: assert property (@(posedge clk) disable iff (rst)
        fs_out |=> !fs_out);

endmodule

bind tdm_reframer tdm_reframer_chk chk_i (
    .clk      (bclk),
    .rst      (rst),
    .align_en (align_en),
    .locked   (locked),
    .err      (err),
    .fs_out   (fs_out),
    .sd_out   (sd_out)
);

// File: tb/tdm_reframer_tb_top.sv
`timescale 1ns/100ps
module tdm_reframer_tb_top;

    localparam int W  = 16;
    localparam int PB = 2 * W;
    localparam int FB = 8 * W;

    // Stimulus frames; each is also the expected output frame (R7)
    localparam logic [FB-1:0] ROWS [6] = '{
        128'h8001_7FFE_0000_FFFF_1234_5678_9ABC_DEF0,
        128'hA5A5_5A5A_C3C3_3C3C_0F0F_F0F0_0001_8000,
        128'hFFFF_0000_FFFF_0000_AAAA_5555_1111_EEEE,
        128'h0102_0304_0506_0708_090A_0B0C_0D0E_0F10,
        128'hDEAD_BEEF_CAFE_F00D_0BAD_FACE_7777_2468,
        128'h4000_0002_8000_0001_FEDC_BA98_7654_3210
    };

    logic bclk = 1'b0;
    logic rst = 1'b1;
    logic lrclk = 1'b1;
    logic sdin = 1'b0;
    logic align_en = 1'b0;
    logic pol_rise = 1'b0;
    logic fs_out, sd_out, locked, err;

    int checks = 0;
    int errors = 0;

    tdm_reframer #(.SLOT_W(W)) dut_i (
        .bclk     (bclk),
        .rst      (rst),
        .lrclk    (lrclk),
        .sdin     (sdin),
        .align_en (align_en),
        .pol_rise (pol_rise),
        .fs_out   (fs_out),
        .sd_out   (sd_out),
        .locked   (locked),
        .err      (err)
    );

    always #2 bclk = ~bclk;

    // Output monitor
    logic [FB-1:0] cap;
    logic [FB-1:0] got [16];
    int  ncap = 0, ngot = 0, cyc = 0, last_fs = 0;
    int  gap_bad = 0, idle_bad = 0;
    bit  have_fs = 0, prev_locked = 0;

    always @(posedge bclk) begin
        #0.5;
        cyc++;
        if (rst) begin
            ncap = 0; have_fs = 0; prev_locked = 0;
        end else begin
            if (!locked && !prev_locked && (fs_out || sd_out)) idle_bad++;
            if (!locked) begin
                ncap = 0; have_fs = 0;
            end else if (fs_out) begin
                if (have_fs && (cyc - last_fs != FB)) gap_bad++;
                have_fs = 1; last_fs = cyc;
                cap = {{(FB-1){1'b0}}, sd_out};
                ncap = 1;
            end else if (ncap > 0) begin
                cap = {cap[FB-2:0], sd_out};
                ncap++;
            end
            if (ncap == FB) begin
                if (ngot < 16) got[ngot] = cap;
                ngot++;
                ncap = 0;
            end
            prev_locked = locked;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [FB-1:0] act, input logic [FB-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic settle();
        @(posedge bclk);
        #1;
    endtask

    // Drives posedges 1..len of one period; the last one carries the active edge
    task automatic send_period(input logic [PB-1:0] w, input bit raise, input int len);
        for (int j = 0; j < len; j++) begin
            @(negedge bclk);
            lrclk = ((j + 1 < W) || (j == len - 1)) ? pol_rise : ~pol_rise;
            sdin  = (j < PB) ? w[PB-1-j] : 1'b0;
            if (raise && j == W) align_en = 1'b1;
        end
    endtask

    task automatic send_frame(input logic [FB-1:0] f, input bit raise);
        for (int p = 0; p < 4; p++)
            send_period(f[FB-1-p*PB -: PB], raise && (p == 0), PB);
    endtask

    task automatic run_pass(input bit pol, input bit long_bad);
        int base;
        rst = 1'b1; pol_rise = pol; align_en = 1'b0; lrclk = ~pol; sdin = 1'b0;
        repeat (4) @(negedge bclk);
        rst = 1'b0;
        ngot = 0; idle_bad = 0; gap_bad = 0;
        settle();
        // R10 reset state
        check(locked == 0, "R10", "locked after reset", FB'(locked), '0);
        check(err == 0,    "R10", "err after reset",    FB'(err),    '0);
        check(fs_out == 0 && sd_out == 0, "R10", "outputs after reset",
              FB'({fs_out, sd_out}), '0);

        // R3 no lock from word-clock edges alone
        send_frame(ROWS[0], 0);
        send_frame(ROWS[1], 0);
        settle();
        check(locked == 0, "R3", "locked without enable", FB'(locked), '0);
        check(idle_bad == 0, "R5", "activity while unlocked", FB'(idle_bad), '0);

        // R4 anchor at the edge closing the channel 1-2 period
        send_period(ROWS[2][FB-1 -: PB], 1, PB);
        check(locked == 0, "R4", "locked before anchor edge", FB'(locked), '0);
        settle();
        check(locked == 1, "R4", "locked after anchor edge", FB'(locked), FB'(1));
        for (int p = 1; p < 4; p++) send_period(ROWS[2][FB-1-p*PB -: PB], 0, PB);
        align_en = 1'b0;
        send_frame(ROWS[3], 0);
        send_frame(ROWS[4], 0);
        send_frame(ROWS[5], 0);
        send_frame(ROWS[0], 0);
        settle();
        check(ngot == 4, "R6", "frames emitted", FB'(ngot), FB'(4));
        check(got[0] == ROWS[2], "R7 R2 R1", "frame 0", got[0], ROWS[2]);
        check(got[1] == ROWS[3], "R7 R2 R1", "frame 1", got[1], ROWS[3]);
        check(got[2] == ROWS[4], "R7 R2 R1", "frame 2", got[2], ROWS[4]);
        check(got[3] == ROWS[5], "R7 R2 R1", "frame 3", got[3], ROWS[5]);
        check(gap_bad == 0, "R6", "sync spacing", FB'(gap_bad), '0);

        // R8 period length violation
        align_en = 1'b1;
        send_period(ROWS[1][FB-1 -: PB], 0, long_bad ? PB + 3 : PB - 2);
        settle();
        check(err == 1,    "R8", "err after bad period",    FB'(err),    FB'(1));
        check(locked == 0, "R8", "locked after bad period", FB'(locked), '0);

        // R9 no relock while enable stays high, nor with enable only low
        send_frame(ROWS[4], 0);
        settle();
        check(locked == 0, "R9", "relock with enable held", FB'(locked), '0);
        align_en = 1'b0;
        send_frame(ROWS[5], 0);
        settle();
        check(locked == 0, "R9", "relock with enable low", FB'(locked), '0);
        base = ngot;
        send_frame(ROWS[1], 1);
        settle();
        check(locked == 1, "R9", "relock after new enable", FB'(locked), FB'(1));
        check(err == 0,    "R9", "err cleared at anchor",   FB'(err),    '0);
        align_en = 1'b0;
        send_frame(ROWS[3], 0);
        send_frame(ROWS[0], 0);
        settle();
        check(ngot - base == 2, "R6", "frames after relock", FB'(ngot - base), FB'(2));
        check(got[base] == ROWS[1],     "R7", "relock frame 0", got[base],     ROWS[1]);
        check(got[base + 1] == ROWS[3], "R7", "relock frame 1", got[base + 1], ROWS[3]);
        check(gap_bad == 0,  "R6", "sync spacing after relock", FB'(gap_bad), '0);
        check(idle_bad == 0, "R5", "activity while unlocked",   FB'(idle_bad), '0);
    endtask

    initial begin
        run_pass(1'b0, 1'b0);
        run_pass(1'b1, 1'b1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog run did not finish actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule